// File: doc/BRIEF.md
# Dual-Operand Effective Address Generator

This block forms the source and destination operand addresses for a 16-bit load/store datapath built around sixteen working registers. Each operand carries its own addressing-mode select, pointer register number, direction bit and literal. One offset-register number serves both operands. A single size input chooses byte or word stepping for the pointer modify modes.

The working registers live inside the block. When an operation is strobed, the block latches both addresses, flags which operands are register operands rather than memory addresses, and commits any pointer updates to the register file on the same clock edge. A plain write port loads register values from the rest of the datapath. The register-operand mode returns the register contents on the address output, so register values can be read back through the normal interface.

Top module: `dual_ea_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every working register is cleared to 0, and `out_valid`, both address outputs, both operand-kind flags and both update flags are cleared to 0.
- R2: Mode code 0 (explicit address) gives the operand's literal as its address, and the pointer register is left unchanged.
- R3: Mode code 1 (register operand) puts the register's contents on the address output with its `*_is_reg` flag at 1. Every other mode leaves the flag at 0.
- R4: Mode code 2 (indirect) and the reserved code 7 both give the pointer register's contents as the address and leave the register unchanged.
- R5: Mode code 3 (post-modify) gives the unmodified register as the address and writes back the register plus the step, or minus the step when the operand's `*_dec` bit is 1. The `*_upd` flag is 1.
- R6: Mode code 4 (pre-modify) adjusts the register by plus or minus the step first, chosen by `*_dec`. The adjusted value is both the address and the written-back register value.
- R7: The modify step is 1 when `op_byte` is 1 and 2 when it is 0.
- R8: Mode code 5 (indexed) gives the pointer register plus the register named by the shared `ofs_reg` field. Both operands use that same offset register.
- R9: Mode code 6 (literal offset) gives the pointer register plus the operand's 16-bit literal.
- R10: All address and modify arithmetic wraps modulo 2^16.
- R11: When the source operand modifies a register, any destination read of that register in the same operation sees the source-updated value. If both operands modify the same register, the destination's result is the final register value.
- R12: Results appear on the outputs, with `out_valid` at 1, in the cycle after the edge that samples `op_valid`. Without `op_valid`, `out_valid` is 0 and the address outputs hold. An operation issued in the next cycle sees the committed updates.
- R13: `wr_en` loads `wr_data` into register `wr_idx`. If a pointer update targets the same register in the same cycle, the pointer update wins. A write to a different register still commits.
- R14: With `op_valid` at 0, the mode inputs change no working register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; commits pointer updates |
| op_byte | input | 1 | 1 = byte step (1), 0 = word step (2) |
| src_mode | input | 3 | Source addressing mode code |
| src_dec | input | 1 | Source modify direction, 1 = decrement |
| src_reg | input | 4 | Source pointer register number |
| src_lit | input | 16 | Source literal (explicit address or offset) |
| dst_mode | input | 3 | Destination addressing mode code |
| dst_dec | input | 1 | Destination modify direction, 1 = decrement |
| dst_reg | input | 4 | Destination pointer register number |
| dst_lit | input | 16 | Destination literal |
| ofs_reg | input | 4 | Shared offset register number for indexed mode |
| wr_en | input | 1 | Register load enable |
| wr_idx | input | 4 | Register load index |
| wr_data | input | 16 | Register load value |
| out_valid | output | 1 | Outputs hold a fresh result |
| src_ea | output | 16 | Source address or register contents |
| src_is_reg | output | 1 | Source is a register operand |
| src_upd | output | 1 | Source pointer was updated |
| dst_ea | output | 16 | Destination address or register contents |
| dst_is_reg | output | 1 | Destination is a register operand |
| dst_upd | output | 1 | Destination pointer was updated |

## Verification
The assertions watch, on every cycle, the relations that hold at all times. `out_valid` tracks the strobe one cycle later, and the outputs hold when idle. The register-operand flag follows the mode. Every modify step differs from its base by exactly the chosen step. A post-modify address equals the pre-update register. The register file stays still without any write. When both operands hit one register, the destination's value lands. The bench scenarios alone show the arithmetic results against hand-computed values: indexed sums through the shared offset field, literal offsets that wrap, and the chained source-then-destination update of one register. They also show the write-port conflict and back-to-back operations that read freshly committed pointers.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    AM_FILE = 3'd0,
    AM_REG  = 3'd1,
    AM_IND  = 3'd2,
    AM_POST = 3'd3,
    AM_PRE  = 3'd4,
    AM_IDX  = 3'd5,
    AM_LIT  = 3'd6,
    AM_RSVD = 3'd7
  } am_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [DW-1:0] ext_data,
  input  logic          s_we,
  input  logic [IW-1:0] s_idx,
  input  logic [DW-1:0] s_data,
  input  logic          d_we,
  input  logic [IW-1:0] d_idx,
  input  logic [DW-1:0] d_data,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  input  logic [IW-1:0] rc_idx,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  output logic [DW-1:0] rc_data
);
  logic [NREG-1:0][DW-1:0] regs;

  // priority per entry: destination update, then source update, then load port
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                           regs[i] <= '0;
      else if (d_we && d_idx == IW'(i))  regs[i] <= d_data;
      else if (s_we && s_idx == IW'(i))  regs[i] <= s_data;
      else if (ext_we && ext_idx == IW'(i)) regs[i] <= ext_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rc_data = regs[rc_idx];

  // R14: no write request, no change
  p_quiet_r14: assert property (@(posedge clk) disable iff (rst)
    (!s_we && !d_we && !ext_we) |=> $stable(regs));

  // R11: destination value lands when both updates target one entry
  p_dst_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (s_we && d_we && s_idx == d_idx) |=> regs[$past(d_idx)] == $past(d_data));
endmodule

// File: rtl/ea_operand.sv
module ea_operand
  import ea_gen_pkg::*;
#(
  parameter int DW = 16
) (
  input  am_e           mode,
  input  logic          dec,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] offs,
  input  logic [DW-1:0] lit,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] ea,
  output logic          is_reg,
  output logic          mod_en,
  output logic [DW-1:0] nv
);
  logic [DW-1:0] adj;

  assign adj = dec ? base - step : base + step;

  always_comb begin
    ea     = base;
    is_reg = 1'b0;
    mod_en = 1'b0;
    nv     = base;
    case (mode)
      AM_FILE: ea = lit;
      AM_REG:  is_reg = 1'b1;
      AM_POST: begin mod_en = 1'b1; nv = adj; end
      AM_PRE:  begin mod_en = 1'b1; nv = adj; ea = adj; end
      AM_IDX:  ea = base + offs;
      AM_LIT:  ea = base + lit;
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_ea_gen.sv
module dual_ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_byte,
  input  logic [2:0]    src_mode,
  input  logic          src_dec,
  input  logic [IW-1:0] src_reg,
  input  logic [DW-1:0] src_lit,
  input  logic [2:0]    dst_mode,
  input  logic          dst_dec,
  input  logic [IW-1:0] dst_reg,
  input  logic [DW-1:0] dst_lit,
  input  logic [IW-1:0] ofs_reg,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          out_valid,
  output logic [DW-1:0] src_ea,
  output logic          src_is_reg,
  output logic          src_upd,
  output logic [DW-1:0] dst_ea,
  output logic          dst_is_reg,
  output logic          dst_upd
);
  logic [DW-1:0] step;
  logic [DW-1:0] rd_s, rd_d, rd_b;
  logic [DW-1:0] d_base, d_offs;
  logic [DW-1:0] s_ea, s_new, d_ea, d_new;
  logic          s_isr, s_mod, d_isr, d_mod;

  assign step = op_byte ? DW'(1) : DW'(2);

  ea_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk(clk), .rst(rst),
    .ext_we(wr_en), .ext_idx(wr_idx), .ext_data(wr_data),
    .s_we(op_valid && s_mod), .s_idx(src_reg), .s_data(s_new),
    .d_we(op_valid && d_mod), .d_idx(dst_reg), .d_data(d_new),
    .ra_idx(src_reg), .rb_idx(dst_reg), .rc_idx(ofs_reg),
    .ra_data(rd_s), .rb_data(rd_d), .rc_data(rd_b)
  );

  ea_operand #(.DW(DW)) src_calc_i (
    .mode(am_e'(src_mode)), .dec(src_dec), .base(rd_s), .offs(rd_b),
    .lit(src_lit), .step(step),
    .ea(s_ea), .is_reg(s_isr), .mod_en(s_mod), .nv(s_new)
  );

  // destination reads see the source-updated pointer
  assign d_base = (s_mod && dst_reg == src_reg) ? s_new : rd_d;
  assign d_offs = (s_mod && ofs_reg == src_reg) ? s_new : rd_b;

  ea_operand #(.DW(DW)) dst_calc_i (
    .mode(am_e'(dst_mode)), .dec(dst_dec), .base(d_base), .offs(d_offs),
    .lit(dst_lit), .step(step),
    .ea(d_ea), .is_reg(d_isr), .mod_en(d_mod), .nv(d_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      src_ea     <= '0;
      src_is_reg <= 1'b0;
      src_upd    <= 1'b0;
      dst_ea     <= '0;
      dst_is_reg <= 1'b0;
      dst_upd    <= 1'b0;
    end else begin
      out_valid <= op_valid;
      if (op_valid) begin
        src_ea     <= s_ea;
        src_is_reg <= s_isr;
        src_upd    <= s_mod;
        dst_ea     <= d_ea;
        dst_is_reg <= d_isr;
        dst_upd    <= d_mod;
      end
    end
  end

  // R12: result strobe follows the operation strobe by one cycle
  p_valid_r12: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> out_valid);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!out_valid && $stable(src_ea) && $stable(dst_ea)));

  // R3: register-operand flag follows the mode code
  p_regflag_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (src_is_reg == ($past(src_mode) == 3'd1)));

  // R7: any modify moves the pointer by exactly one step
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && s_mod) |-> ((s_new - rd_s) == step || (rd_s - s_new) == step));

  // R5: post-modify addresses with the register value before update
  p_post_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && src_mode == 3'd3) |=> src_ea == $past(rd_s));
endmodule

// File: tb/dual_ea_gen_tb_top.sv
`timescale 1ns/100ps
module dual_ea_gen_tb_top;
  localparam logic [2:0] M_FILE = 3'd0, M_REG = 3'd1, M_IND = 3'd2, M_POST = 3'd3,
                         M_PRE = 3'd4, M_IDX = 3'd5, M_LIT = 3'd6, M_RSVD = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0, op_byte = 1'b0;
  logic [2:0]  src_mode = '0, dst_mode = '0;
  logic        src_dec = 1'b0, dst_dec = 1'b0;
  logic [3:0]  src_reg = '0, dst_reg = '0, ofs_reg = '0, wr_idx = '0;
  logic [15:0] src_lit = '0, dst_lit = '0, wr_data = '0;
  logic        wr_en = 1'b0;
  logic        out_valid, src_is_reg, src_upd, dst_is_reg, dst_upd;
  logic [15:0] src_ea, dst_ea;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dual_ea_gen dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
    .src_mode(src_mode), .src_dec(src_dec), .src_reg(src_reg), .src_lit(src_lit),
    .dst_mode(dst_mode), .dst_dec(dst_dec), .dst_reg(dst_reg), .dst_lit(dst_lit),
    .ofs_reg(ofs_reg), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .out_valid(out_valid), .src_ea(src_ea), .src_is_reg(src_is_reg), .src_upd(src_upd),
    .dst_ea(dst_ea), .dst_is_reg(dst_is_reg), .dst_upd(dst_upd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_op(input logic [2:0] sm, input logic sd, input logic [3:0] sr,
                        input logic [15:0] sl, input logic [2:0] dm, input logic dd,
                        input logic [3:0] dr, input logic [15:0] dl,
                        input logic [3:0] ob, input logic byt);
    src_mode = sm; src_dec = sd; src_reg = sr; src_lit = sl;
    dst_mode = dm; dst_dec = dd; dst_reg = dr; dst_lit = dl;
    ofs_reg = ob; op_byte = byt;
  endtask

  // one strobed operation; returns at the negedge where results are visible
  task automatic run_op(input logic [2:0] sm, input logic sd, input logic [3:0] sr,
                        input logic [15:0] sl, input logic [2:0] dm, input logic dd,
                        input logic [3:0] dr, input logic [15:0] dl,
                        input logic [3:0] ob, input logic byt);
    @(negedge clk);
    set_op(sm, sd, sr, sl, dm, dd, dr, dl, ob, byt);
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load(input logic [3:0] idx, input logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [15:0] val);
    run_op(M_REG, 1'b0, idx, 16'h0, M_REG, 1'b0, idx, 16'h0, 4'd0, 1'b0);
    val = src_ea;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 out_valid", {15'd0, out_valid}, 16'h0);
    chk("R1 src_ea", src_ea, 16'h0);
    chk("R1 dst_upd", {15'd0, dst_upd}, 16'h0);
    peek(4'd5, v);
    chk("R1 reg5 cleared", v, 16'h0);
  endtask

  task automatic t_file_direct;
    logic [15:0] v;
    load(4'd3, 16'h1234);
    run_op(M_FILE, 1'b0, 4'd3, 16'h0ABC, M_FILE, 1'b0, 4'd3, 16'hFFFE, 4'd0, 1'b0);
    chk("R2 src explicit", src_ea, 16'h0ABC);
    chk("R2 dst explicit", dst_ea, 16'hFFFE);
    chk("R2 is_reg low", {15'd0, src_is_reg}, 16'h0);
    peek(4'd3, v);
    chk("R2 reg unchanged", v, 16'h1234);
  endtask

  task automatic t_reg_and_ind;
    logic [15:0] v;
    run_op(M_REG, 1'b0, 4'd3, 16'h0, M_IND, 1'b0, 4'd3, 16'h0, 4'd0, 1'b0);
    chk("R3 reg operand value", src_ea, 16'h1234);
    chk("R3 is_reg high", {15'd0, src_is_reg}, 16'h1);
    chk("R3 indirect is_reg low", {15'd0, dst_is_reg}, 16'h0);
    chk("R4 indirect addr", dst_ea, 16'h1234);
    run_op(M_RSVD, 1'b1, 4'd3, 16'h5555, M_IND, 1'b0, 4'd0, 16'h0, 4'd0, 1'b1);
    chk("R4 reserved code addr", src_ea, 16'h1234);
    chk("R4 reserved no update", {15'd0, src_upd}, 16'h0);
    peek(4'd3, v);
    chk("R4 reg unchanged", v, 16'h1234);
  endtask

  task automatic t_post;
    logic [15:0] v;
    load(4'd4, 16'h0100);
    run_op(M_POST, 1'b0, 4'd4, 16'h0, M_FILE, 1'b0, 4'd0, 16'h0, 4'd0, 1'b0);
    chk("R5 post addr", src_ea, 16'h0100);
    chk("R5 upd flag", {15'd0, src_upd}, 16'h1);
    peek(4'd4, v);
    chk("R5 R7 post inc word", v, 16'h0102);
    run_op(M_FILE, 1'b0, 4'd0, 16'h0, M_POST, 1'b1, 4'd4, 16'h0, 4'd0, 1'b1);
    chk("R5 dst post addr", dst_ea, 16'h0102);
    peek(4'd4, v);
    chk("R5 R7 post dec byte", v, 16'h0101);
  endtask

  task automatic t_pre;
    logic [15:0] v;
    load(4'd6, 16'h0200);
    run_op(M_PRE, 1'b1, 4'd6, 16'h0, M_FILE, 1'b0, 4'd0, 16'h0, 4'd0, 1'b0);
    chk("R6 pre dec word addr", src_ea, 16'h01FE);
    peek(4'd6, v);
    chk("R6 pre dec word reg", v, 16'h01FE);
    run_op(M_PRE, 1'b0, 4'd6, 16'h0, M_FILE, 1'b0, 4'd0, 16'h0, 4'd0, 1'b1);
    chk("R6 R7 pre inc byte addr", src_ea, 16'h01FF);
  endtask

  task automatic t_indexed_literal;
    load(4'd7, 16'h1000);
    load(4'd8, 16'h0030);
    load(4'd9, 16'h2000);
    run_op(M_IDX, 1'b0, 4'd7, 16'h0, M_IDX, 1'b0, 4'd9, 16'h0, 4'd8, 1'b0);
    chk("R8 src indexed", src_ea, 16'h1030);
    chk("R8 dst shared offset", dst_ea, 16'h2030);
    run_op(M_LIT, 1'b0, 4'd7, 16'hFFF0, M_LIT, 1'b0, 4'd9, 16'h0005, 4'd0, 1'b0);
    chk("R9 R10 literal wrap", src_ea, 16'h0FF0);
    chk("R9 dst literal", dst_ea, 16'h2005);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    load(4'd10, 16'hFFFF);
    load(4'd11, 16'h0000);
    run_op(M_POST, 1'b0, 4'd10, 16'h0, M_PRE, 1'b1, 4'd11, 16'h0, 4'd0, 1'b0);
    chk("R10 post addr top", src_ea, 16'hFFFF);
    chk("R10 pre dec wrap", dst_ea, 16'hFFFE);
    peek(4'd10, v);
    chk("R10 post inc wrap", v, 16'h0001);
  endtask

  task automatic t_same_reg;
    logic [15:0] v;
    load(4'd12, 16'h0400);
    run_op(M_POST, 1'b0, 4'd12, 16'h0, M_PRE, 1'b0, 4'd12, 16'h0, 4'd0, 1'b0);
    chk("R11 src addr", src_ea, 16'h0400);
    chk("R11 dst sees src update", dst_ea, 16'h0404);
    peek(4'd12, v);
    chk("R11 final dst value", v, 16'h0404);
    run_op(M_PRE, 1'b1, 4'd12, 16'h0, M_POST, 1'b0, 4'd12, 16'h0, 4'd0, 1'b1);
    chk("R11 src pre dec", src_ea, 16'h0403);
    chk("R11 dst post addr", dst_ea, 16'h0403);
    peek(4'd12, v);
    chk("R11 final chained", v, 16'h0404);
  endtask

  task automatic t_write_conflict;
    logic [15:0] v;
    load(4'd13, 16'h0500);
    @(negedge clk);
    set_op(M_POST, 1'b0, 4'd13, 16'h0, M_FILE, 1'b0, 4'd0, 16'h0, 4'd0, 1'b0);
    op_valid = 1'b1; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 16'h7777;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    peek(4'd13, v);
    chk("R13 pointer update wins", v, 16'h0502);
    @(negedge clk);
    set_op(M_POST, 1'b0, 4'd13, 16'h0, M_FILE, 1'b0, 4'd0, 16'h0, 4'd0, 1'b0);
    op_valid = 1'b1; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 16'h1111;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    peek(4'd14, v);
    chk("R13 other reg loads", v, 16'h1111);
    peek(4'd13, v);
    chk("R13 pointer still steps", v, 16'h0504);
  endtask

  task automatic t_timing_idle;
    logic [15:0] v;
    load(4'd4, 16'h0300);
    @(negedge clk);
    set_op(M_POST, 1'b0, 4'd4, 16'h0, M_IND, 1'b0, 4'd0, 16'h0, 4'd0, 1'b0);
    op_valid = 1'b1;
    @(negedge clk);
    chk("R12 valid after op", {15'd0, out_valid}, 16'h1);
    chk("R12 first op addr", src_ea, 16'h0300);
    set_op(M_IND, 1'b0, 4'd4, 16'h0, M_IND, 1'b0, 4'd0, 16'h0, 4'd0, 1'b0);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R12 next op sees update", src_ea, 16'h0302);
    set_op(M_POST, 1'b0, 4'd4, 16'h0, M_PRE, 1'b0, 4'd4, 16'h0, 4'd0, 1'b0);
    @(negedge clk);
    chk("R12 valid drops", {15'd0, out_valid}, 16'h0);
    chk("R12 addr holds", src_ea, 16'h0302);
    @(negedge clk);
    peek(4'd4, v);
    chk("R14 idle modes ignored", v, 16'h0302);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_file_direct();
    t_reg_and_ind();
    t_post();
    t_pre();
    t_indexed_literal();
    t_wrap();
    t_same_reg();
    t_write_conflict();
    t_timing_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule